// File: doc/BRIEF.md
# JTAG Console Byte Bridge

This block is one module on a debug scan chain. It carries a byte stream in both directions between a JTAG host and an on-chip console. It has two 8-entry byte queues. The inbound queue carries bytes from the host to the device. The outbound queue carries bytes from the device to the host.

While the chain is selected, every 72-bit data-register scan does two things at once:
- It delivers a header byte and up to eight data bytes from the host.
- It returns a status header and up to eight bytes that are waiting for the host.

The returned header packs two 4-bit counts. The upper nibble is the number of outbound bytes in this scan. The lower nibble is the number of free inbound entries. The host treats as accepted only the smaller of its own write count and the free count it was given.

On the device side, each direction is a plain valid/ready byte port. The TAP controller drives the capture, shift and update strobes. These strobes are synchronous to `clk` and each lasts one cycle. `chain_sel` qualifies the strobes.

Top module: `jtag_console_bridge`

## Requirements
- R1: On capture while selected, the 72-bit shift register is loaded as follows, and bit 0 appears first on `tdo`:
  - Bits 3:0 hold the number of free inbound entries (8 minus occupancy).
  - Bits 7:4 hold the number of outbound bytes sent in this scan, which is the outbound occupancy capped at 8.
  - Data slot k occupies bits 8k+15 down to 8k+8.
- R2: Outbound bytes fill data slots in queue order, oldest in slot 0. Slots beyond the reported count shift out as zero.
- R3: On update after a complete scan, the block pushes the first N host data slots into the inbound queue in slot order. N is the smallest of three values:
  - the host count in bits 7:4 of the host header;
  - the free count snapshotted at capture;
  - 8.
  Any further slots are dropped.
- R4: Outbound bytes are removed from the queue only by an update that completes a scan, and exactly as many as were reported at capture. A scan with no update leaves the outbound queue intact.
- R5: An update that follows fewer than 72 shift cycles since the last capture commits nothing in either direction. So does a second update without a new capture.
- R6: Shift cycles beyond the 72nd are ignored, so a host that appends a trailing zero bit still gets a normal commit.
- R7: `rx_valid` is high while the inbound queue holds a byte. `rx_data` shows the oldest byte and stays stable until it is taken with `rx_ready`.
- R8: `tx_ready` is low only when the outbound queue holds 8 bytes. A byte is stored when `tx_valid` and `tx_ready` are both high.
- R9: Bytes that the device stores after a capture are neither sent nor removed by that scan's update.
- R10: Capture, shift and update strobes have no effect while `chain_sel` is low.
- R11: After reset both queues are empty: `rx_valid` is 0 and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the block and the TAP strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| chain_sel | input | 1 | This module is the selected debug chain |
| tap_capture | input | 1 | Capture-DR strobe, one cycle |
| tap_shift | input | 1 | Shift-DR enable, one bit per cycle |
| tap_update | input | 1 | Update-DR strobe, one cycle |
| tdi | input | 1 | Serial data from host |
| tdo | output | 1 | Serial data to host |
| rx_data | output | 8 | Oldest inbound byte |
| rx_valid | output | 1 | Inbound byte available |
| rx_ready | input | 1 | Device takes the inbound byte |
| tx_data | input | 8 | Outbound byte from device |
| tx_valid | input | 1 | Outbound byte offered |
| tx_ready | output | 1 | Outbound queue has room |

## Verification
The hardest case to reach is a device write that lands between a capture and its update. The reported count must stay frozen while the queue grows underneath it.

The bench reaches this case by forking the scan task alongside a device-push task that waits a few cycles into the shift phase. Two further cases need deliberately malformed scans:
- a truncated scan followed by an update;
- a scan one bit longer than nominal.

Filling the inbound queue partly before an 8-byte host write covers the rule that takes the smaller of the host count and the free count.

// File: rtl/jcb_pkg.sv
package jcb_pkg;
    localparam int BYTE_W    = 8;
    localparam int SLOTS     = 8;
    localparam int NIB_W     = BYTE_W / 2;
    localparam int CNT_W     = NIB_W;
    localparam int SCAN_BITS = BYTE_W * (SLOTS + 1);
endpackage

// File: rtl/jcb_fifo.sv
module jcb_fifo #(
    parameter int W      = 8,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int PEEK_N = DEPTH
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CNT_W-1:0]            push_n,
    input  logic [DEPTH-1:0][W-1:0]     push_data,
    input  logic [CNT_W-1:0]            pop_n,
    output logic [PEEK_N-1:0][W-1:0]    peek,
    output logic [CNT_W-1:0]            count
);
    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) < push_n) begin
                st_d.mem[PTR_W'(st_q.wr + PTR_W'(i))] = push_data[i];
            end
        end
        st_d.wr  = st_q.wr + PTR_W'(push_n);
        st_d.rd  = st_q.rd + PTR_W'(pop_n);
        st_d.cnt = st_q.cnt + push_n - pop_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        for (genvar k = 0; k < PEEK_N; k++) begin : g_peek
            assign peek[k] = st_q.mem[PTR_W'(st_q.rd + PTR_W'(k))];
        end
    endgenerate

    assign count = st_q.cnt;
endmodule

// File: rtl/jcb_scan.sv
module jcb_scan #(
    parameter int SLOTS  = 8,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sel,
    input  logic                          cap,
    input  logic                          shift,
    input  logic                          upd,
    input  logic                          tdi,
    output logic                          tdo,
    input  logic [SLOTS-1:0][BYTE_W-1:0]  tx_peek,
    input  logic [CNT_W-1:0]              tx_count,
    input  logic [CNT_W-1:0]              rx_count,
    output logic [CNT_W-1:0]              rx_push_n,
    output logic [SLOTS-1:0][BYTE_W-1:0]  rx_push_data,
    output logic [CNT_W-1:0]              tx_pop_n,
    output logic                          scan_full
);
    localparam int SCAN_BITS = BYTE_W * (SLOTS + 1);
    localparam int BC_W      = $clog2(SCAN_BITS + 1);
    localparam int NIB_W     = BYTE_W / 2;
    localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(SLOTS);

    typedef struct packed {
        logic [SCAN_BITS-1:0] sr;
        logic [BC_W-1:0]      bits;
        logic [CNT_W-1:0]     free_snap;
        logic [CNT_W-1:0]     tx_snap;
    } scan_st_t;

    scan_st_t st_d, st_q;

    logic [CNT_W-1:0] tx_avail;
    logic [CNT_W-1:0] free_now;
    logic [CNT_W-1:0] host_cnt;
    logic [CNT_W-1:0] accept_n;
    logic             commit;

    always_comb begin
        tx_avail = (tx_count > SLOTS_C) ? SLOTS_C : tx_count;
        free_now = SLOTS_C - rx_count;
        host_cnt = CNT_W'(st_q.sr[BYTE_W-1:NIB_W]);
        accept_n = host_cnt;
        if (st_q.free_snap < accept_n) accept_n = st_q.free_snap;
        if (SLOTS_C < accept_n)        accept_n = SLOTS_C;
        scan_full = (st_q.bits == BC_W'(SCAN_BITS));
        commit    = sel && upd && scan_full;

        st_d = st_q;
        if (sel && cap) begin
            st_d.sr[BYTE_W-1:0] = {NIB_W'(tx_avail), NIB_W'(free_now)};
            for (int k = 0; k < SLOTS; k++) begin
                st_d.sr[(k+1)*BYTE_W +: BYTE_W] =
                    (CNT_W'(k) < tx_avail) ? tx_peek[k] : '0;
            end
            st_d.bits      = '0;
            st_d.free_snap = free_now;
            st_d.tx_snap   = tx_avail;
        end else if (sel && shift) begin
            if (st_q.bits < BC_W'(SCAN_BITS)) begin
                st_d.sr   = {tdi, st_q.sr[SCAN_BITS-1:1]};
                st_d.bits = st_q.bits + BC_W'(1);
            end
        end else if (sel && upd) begin
            st_d.bits      = '0;
            st_d.free_snap = '0;
            st_d.tx_snap   = '0;
        end

        rx_push_n = commit ? accept_n : '0;
        tx_pop_n  = commit ? st_q.tx_snap : '0;
        for (int k = 0; k < SLOTS; k++) begin
            rx_push_data[k] = st_q.sr[(k+1)*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tdo = st_q.sr[0];
endmodule

// File: rtl/jtag_console_bridge.sv
module jtag_console_bridge #(
    parameter int BYTE_W = jcb_pkg::BYTE_W,
    parameter int SLOTS  = jcb_pkg::SLOTS,
    parameter int CNT_W  = jcb_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chain_sel,
    input  logic              tap_capture,
    input  logic              tap_shift,
    input  logic              tap_update,
    input  logic              tdi,
    output logic              tdo,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready
);
    logic [CNT_W-1:0]             rx_cnt, tx_cnt;
    logic [CNT_W-1:0]             rx_push_n, tx_pop_n;
    logic [CNT_W-1:0]             rx_pop_n, tx_push_n;
    logic [SLOTS-1:0][BYTE_W-1:0] rx_push_data, tx_push_data, tx_peek;
    logic [0:0][BYTE_W-1:0]       rx_head;
    logic                         scan_full;

    always_comb begin
        tx_push_data    = '0;
        tx_push_data[0] = tx_data;
    end

    assign rx_valid  = (rx_cnt != '0);
    assign rx_data   = rx_head[0];
    assign tx_ready  = (tx_cnt != CNT_W'(SLOTS));
    assign rx_pop_n  = {{(CNT_W-1){1'b0}}, (rx_valid && rx_ready)};
    assign tx_push_n = {{(CNT_W-1){1'b0}}, (tx_valid && tx_ready)};

    jcb_fifo #(.W(BYTE_W), .DEPTH(SLOTS), .CNT_W(CNT_W), .PEEK_N(1)) u_rx_q (
        .clk(clk), .rst_n(rst_n),
        .push_n(rx_push_n), .push_data(rx_push_data),
        .pop_n(rx_pop_n), .peek(rx_head), .count(rx_cnt)
    );

    jcb_fifo #(.W(BYTE_W), .DEPTH(SLOTS), .CNT_W(CNT_W), .PEEK_N(SLOTS)) u_tx_q (
        .clk(clk), .rst_n(rst_n),
        .push_n(tx_push_n), .push_data(tx_push_data),
        .pop_n(tx_pop_n), .peek(tx_peek), .count(tx_cnt)
    );

    jcb_scan #(.SLOTS(SLOTS), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .sel(chain_sel),
        .cap(tap_capture), .shift(tap_shift), .upd(tap_update),
        .tdi(tdi), .tdo(tdo),
        .tx_peek(tx_peek), .tx_count(tx_cnt), .rx_count(rx_cnt),
        .rx_push_n(rx_push_n), .rx_push_data(rx_push_data),
        .tx_pop_n(tx_pop_n), .scan_full(scan_full)
    );
endmodule

// File: rtl/jcb_checker.sv
module jcb_checker #(
    parameter int BYTE_W = 8,
    parameter int SLOTS  = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              upd,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [BYTE_W-1:0] rx_data,
    input logic [CNT_W-1:0]  rx_cnt,
    input logic [CNT_W-1:0]  tx_cnt,
    input logic              scan_full
);
    AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CNT_W'(SLOTS)); // R3
    AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CNT_W'(SLOTS)); // R8
    AST_TX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && upd) |=> tx_cnt >= $past(tx_cnt)); // R4
    AST_SHORT_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && upd && !scan_full) |=> rx_cnt <= $past(rx_cnt)); // R5
    AST_UNSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> rx_cnt <= $past(rx_cnt)); // R10
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R7
endmodule

bind jtag_console_bridge jcb_checker #(.BYTE_W(BYTE_W), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel(chain_sel), .upd(tap_update),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .scan_full(scan_full)
);

// File: tb/tb_jtag_console_bridge.sv
`timescale 1ns/1ps
module tb_jtag_console_bridge;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chain_sel = 1'b0, tap_capture = 1'b0, tap_shift = 1'b0, tap_update = 1'b0;
    logic tdi = 1'b0, tdo;
    logic [7:0] rx_data, tx_data = 8'h0;
    logic rx_valid, rx_ready = 1'b0, tx_valid = 1'b0, tx_ready;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    jtag_console_bridge dut (
        .clk(clk), .rst_n(rst_n), .chain_sel(chain_sel),
        .tap_capture(tap_capture), .tap_shift(tap_shift), .tap_update(tap_update),
        .tdi(tdi), .tdo(tdo), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_scan(input logic [7:0] hdr, input logic [63:0] data, input int nbits,
                           input bit do_upd, output logic [71:0] got);
        logic [71:0] payload;
        payload = {data, hdr};
        got = '0;
        tap_capture = 1'b1;
        @(negedge clk);
        tap_capture = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            if (i < 72) got[i] = tdo;
            tdi = (i < 72) ? payload[i] : 1'b0;
            tap_shift = 1'b1;
            @(negedge clk);
        end
        tap_shift = 1'b0;
        tdi = 1'b0;
        if (do_upd) begin
            tap_update = 1'b1;
            @(negedge clk);
            tap_update = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic push_tx(input logic [7:0] b);
        tx_data = b;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic pop_rx(input string req, input logic [7:0] exp);
        chk(req, {71'h0, rx_valid}, 72'h1);
        chk(req, {64'h0, rx_data}, {64'h0, exp});
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11 rx_valid", {71'h0, rx_valid}, 72'h0);
        chk("R11 tx_ready", {71'h0, tx_ready}, 72'h1);
    endtask

    task automatic t_empty_scan;
        logic [71:0] g;
        do_scan(8'h00, 64'h0, 72, 1'b1, g);
        chk("R1 R2 empty header and zero slots", g, {64'h0, 8'h08});
    endtask

    task automatic t_tx_basic;
        logic [71:0] g;
        push_tx(8'hA1); push_tx(8'hB2); push_tx(8'hC3);
        do_scan(8'h00, 64'h0, 72, 1'b1, g);
        chk("R1 R2 three outbound bytes", g, {64'h0000_0000_00C3_B2A1, 8'h38});
        do_scan(8'h00, 64'h0, 72, 1'b1, g);
        chk("R4 outbound popped on update", g, {64'h0, 8'h08});
    endtask

    task automatic t_rx_limit;
        logic [71:0] g;
        do_scan(8'h50, 64'h0000_0015_1413_1211, 72, 1'b1, g);
        chk("R1 free count before write", g, {64'h0, 8'h08});
        do_scan(8'h80, 64'h2827_2625_2423_2221, 72, 1'b1, g);
        chk("R1 free count three", g, {64'h0, 8'h03});
        pop_rx("R3 R7 order", 8'h11); pop_rx("R3 R7 order", 8'h12);
        pop_rx("R3 R7 order", 8'h13); pop_rx("R3 R7 order", 8'h14);
        pop_rx("R3 R7 order", 8'h15); pop_rx("R3 min with free", 8'h21);
        pop_rx("R3 min with free", 8'h22); pop_rx("R3 min with free", 8'h23);
        chk("R3 extra bytes dropped", {71'h0, rx_valid}, 72'h0);
    endtask

    task automatic t_rx_clamp;
        logic [71:0] g;
        do_scan(8'hF0, 64'h3837_3635_3433_3231, 72, 1'b1, g);
        for (int i = 0; i < 8; i++) pop_rx("R3 count clamp to eight", 8'h31 + 8'(i));
        chk("R3 clamp no ninth byte", {71'h0, rx_valid}, 72'h0);
    endtask

    task automatic t_abort;
        logic [71:0] g;
        push_tx(8'h44); push_tx(8'h55);
        do_scan(8'h00, 64'h0, 72, 1'b0, g);
        chk("R4 scan without update", g, {64'h0000_0000_0000_5544, 8'h28});
        do_scan(8'h10, 64'h99, 40, 1'b1, g);
        chk("R5 short scan no inbound", {71'h0, rx_valid}, 72'h0);
        tap_update = 1'b1; @(negedge clk); tap_update = 1'b0; @(negedge clk);
        chk("R5 repeated update no inbound", {71'h0, rx_valid}, 72'h0);
        do_scan(8'h10, 64'h66, 72, 1'b1, g);
        chk("R4 R5 data survives abort", g, {64'h0000_0000_0000_5544, 8'h28});
        pop_rx("R3 single byte", 8'h66);
        do_scan(8'h00, 64'h0, 72, 1'b1, g);
        chk("R4 popped after full scan", g, {64'h0, 8'h08});
    endtask

    task automatic t_extra_bit;
        logic [71:0] g;
        do_scan(8'h20, 64'h8877, 73, 1'b1, g);
        chk("R6 header with trailing bit", g, {64'h0, 8'h08});
        pop_rx("R6 trailing bit ignored", 8'h77);
        pop_rx("R6 trailing bit ignored", 8'h88);
    endtask

    task automatic t_tx_full;
        logic [71:0] g;
        for (int i = 0; i < 8; i++) push_tx(8'hA0 + 8'(i));
        chk("R8 full drops ready", {71'h0, tx_ready}, 72'h0);
        do_scan(8'h00, 64'h0, 72, 1'b1, g);
        chk("R1 R2 full outbound", g, {64'hA7A6_A5A4_A3A2_A1A0, 8'h88});
        chk("R8 ready after drain", {71'h0, tx_ready}, 72'h1);
    endtask

    task automatic t_snapshot;
        logic [71:0] g;
        push_tx(8'hB1);
        fork
            do_scan(8'h00, 64'h0, 72, 1'b1, g);
            begin
                repeat (5) @(negedge clk);
                push_tx(8'hB2);
                push_tx(8'hB3);
            end
        join
        chk("R9 snapshot count", g, {64'h0000_0000_0000_00B1, 8'h18});
        do_scan(8'h00, 64'h0, 72, 1'b1, g);
        chk("R9 late bytes kept", g, {64'h0000_0000_0000_B3B2, 8'h28});
    endtask

    task automatic t_unselected;
        logic [71:0] g;
        push_tx(8'hD1);
        chain_sel = 1'b0;
        do_scan(8'h10, 64'hCC, 72, 1'b1, g);
        chain_sel = 1'b1;
        @(negedge clk);
        chk("R10 no inbound when unselected", {71'h0, rx_valid}, 72'h0);
        do_scan(8'h00, 64'h0, 72, 1'b1, g);
        chk("R10 outbound kept when unselected", g, {64'h0000_0000_0000_00D1, 8'h18});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        chain_sel = 1'b1;
        @(negedge clk);
        t_empty_scan();
        t_tx_basic();
        t_rx_limit();
        t_rx_clamp();
        t_abort();
        t_extra_bit();
        t_tx_full();
        t_snapshot();
        t_unselected();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule